// File: doc/BRIEF.md
# Pulse-Swallow Modulus Control Counter

This block steers a dual-modulus prescaler (divide by 8 or by 9) in an integer-N synthesizer loop. It runs on the prescaler's output clock and produces a frame of exactly 32 clock cycles. The frame uses a single 5-bit up/down counter. The counter climbs from zero until it equals the channel code. It then spends one cycle reloading itself with 28 and falls until it equals the code again. A final wrap cycle returns it to zero.

The modulus control output is high for the whole climbing phase, so the prescaler divides by 9 for (code + 1) of the 32 pulses and by 8 for the rest. The total division therefore steps by one for each code step. A direction flag marks the falling phase, and a one-cycle done pulse marks the last cycle of every frame. Equality with the code is found with a per-bit XOR compare. Each counter bit is a toggle stage whose toggle condition comes from a carry or borrow chain.

Top module: `psw_mod_ctrl`

## Requirements
- R1: While `rst_n` is low, `mod_ctrl` is 1, `count_down` is 0 and `frame_done` is 0, whatever `chan_code` does. Asserting `rst_n` acts at once, without waiting for a clock edge.
- R2: Every frame after the first one following reset lasts exactly 32 clock cycles. `frame_done` is high only in the last cycle of each frame.
- R3: In each frame `mod_ctrl` is high in one contiguous run of (c + 1) cycles that starts in the frame's first cycle. Here c is the effective channel code.
- R4: The cycle right after `mod_ctrl` falls is a reload cycle with `mod_ctrl`, `count_down` and `frame_done` all 0. `count_down` is then high for (29 − c) cycles and falls into the done cycle.
- R5: A `chan_code` value from 28 to 31 is clamped, so c = 27 and the falling phase still has two counted cycles. Values 0 to 27 are used as given, with c equal to the 5-bit unsigned value.
- R6: `chan_code` is taken in the first cycle of each frame. Later changes within that frame do not affect that frame's output pattern.
- R7: In the done cycle `mod_ctrl` and `count_down` are 0. In the following cycle `mod_ctrl` is 1, because the next frame starts counting from zero.
- R8: `mod_ctrl` and `count_down` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| chan_code | input | 5 | Channel code, unsigned |
| mod_ctrl | output | 1 | Modulus control: 1 selects divide by 9, 0 selects divide by 8 |
| count_down | output | 1 | High while the counter is in its falling phase |
| frame_done | output | 1 | One-cycle pulse in the last cycle of each 32-cycle frame |

## Verification
The hardest case to reach is a channel code change that lands inside a frame after the code has been captured. The block must finish that frame with the old pattern and only then adopt the new code. The driver changes `chan_code` in the falling edge right after a done pulse, so the new value is present in the frame's first cycle. A few cycles later it writes a different value, including an out-of-range one. The scoreboard still expects the first code's counts for that frame. A reset is also forced in the middle of a frame, to show that the outputs return to their reset values at once and that the next full frame lines up again.

// File: rtl/psw_pkg.sv
package psw_pkg;

  // Frame phases of the modulus control counter
  typedef enum logic [1:0] {
    PH_UP   = 2'd0,  // counting up from zero, modulus control high
    PH_LOAD = 2'd1,  // one cycle spent loading the reload value
    PH_DOWN = 2'd2,  // counting down from the reload value
    PH_WRAP = 2'd3   // one cycle spent clearing back to zero
  } phase_e;

endpackage

// File: rtl/psw_rst_sync.sv
module psw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_nxt;

  always_comb begin
    sync_nxt = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_nxt;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/psw_toggle_counter.sv
module psw_toggle_counter #(
  parameter int          W        = 5,
  parameter int unsigned LOAD_VAL = 28
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,   // advance by one this cycle
  input  logic         cnt_dn,   // 1: count down, 0: count up
  input  logic         ld_top,   // load LOAD_VAL
  input  logic         clr,      // clear to zero
  output logic [W-1:0] q
);

  localparam logic [W-1:0] LOAD_BITS = W'(LOAD_VAL);

  logic [W-1:0] up_c;    // all lower bits are one
  logic [W-1:0] dn_c;    // all lower bits are zero
  logic [W-1:0] tgl;
  logic [W-1:0] q_nxt;

  // Each bit is a toggle stage: it flips when every lower bit is one
  // (counting up) or zero (counting down).
  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_stage
      if (i == 0) begin : g_lsb
        assign up_c[i] = 1'b1;
        assign dn_c[i] = 1'b1;
      end else begin : g_upper
        assign up_c[i] = up_c[i-1] & q[i-1];
        assign dn_c[i] = dn_c[i-1] & ~q[i-1];
      end
      assign tgl[i] = cnt_dn ? dn_c[i] : up_c[i];
    end
  endgenerate

  always_comb begin
    if (clr) begin
      q_nxt = '0;
    end else if (ld_top) begin
      q_nxt = LOAD_BITS;
    end else if (cnt_en) begin
      q_nxt = q ^ tgl;
    end else begin
      q_nxt = q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= q_nxt;
    end
  end

endmodule

// File: rtl/psw_code_match.sv
module psw_code_match #(
  parameter int W = 5
) (
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] code,
  output logic         match
);

  logic [W-1:0] diff;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_xor
      assign diff[i] = cnt[i] ^ code[i];
    end
  endgenerate

  assign match = ~|diff;

endmodule

// File: rtl/psw_code_hold.sv
module psw_code_hold #(
  parameter int          W        = 5,
  parameter int unsigned MAX_CODE = 27
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frame_start,
  input  logic [W-1:0] chan_in,
  output logic [W-1:0] cur_code
);

  localparam logic [W-1:0] MAX_BITS = W'(MAX_CODE);

  logic [W-1:0] clamped;
  logic [W-1:0] code_q;
  logic [W-1:0] code_nxt;

  assign clamped  = (chan_in > MAX_BITS) ? MAX_BITS : chan_in;
  // The first cycle of a frame compares against the live code; the rest
  // of the frame uses the captured copy.
  assign cur_code = frame_start ? clamped : code_q;

  always_comb begin
    code_nxt = code_q;
    if (frame_start) begin
      code_nxt = clamped;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else begin
      code_q <= code_nxt;
    end
  end

endmodule

// File: rtl/psw_phase_ctrl.sv
module psw_phase_ctrl
  import psw_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   match,
  output phase_e phase_q,
  output logic   cnt_en,
  output logic   cnt_dn,
  output logic   ld_top,
  output logic   clr
);

  phase_e phase_nxt;

  always_comb begin
    phase_nxt = phase_q;
    cnt_en    = 1'b0;
    cnt_dn    = 1'b0;
    ld_top    = 1'b0;
    clr       = 1'b0;
    case (phase_q)
      PH_UP: begin
        if (match) begin
          phase_nxt = PH_LOAD;
        end else begin
          cnt_en = 1'b1;
        end
      end
      PH_LOAD: begin
        ld_top    = 1'b1;
        phase_nxt = PH_DOWN;
      end
      PH_DOWN: begin
        cnt_dn = 1'b1;
        if (match) begin
          phase_nxt = PH_WRAP;
        end else begin
          cnt_en = 1'b1;
        end
      end
      PH_WRAP: begin
        clr       = 1'b1;
        phase_nxt = PH_UP;
      end
      default: begin
        clr       = 1'b1;
        phase_nxt = PH_UP;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_UP;
    end else begin
      phase_q <= phase_nxt;
    end
  end

endmodule

// File: rtl/psw_mod_ctrl.sv
module psw_mod_ctrl
  import psw_pkg::*;
#(
  parameter int          CNT_W  = 5,
  parameter int unsigned RELOAD = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] chan_code,
  output logic             mod_ctrl,
  output logic             count_down,
  output logic             frame_done
);

  localparam int unsigned MAX_CODE = RELOAD - 1;

  logic             rst_n_int;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cur_code;
  logic             match;
  logic             frame_start;
  phase_e           phase_q;
  logic             cnt_en;
  logic             cnt_dn;
  logic             ld_top;
  logic             clr;

  psw_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  assign frame_start = (phase_q == PH_UP) && (cnt == '0);

  psw_code_hold #(.W(CNT_W), .MAX_CODE(MAX_CODE)) u_code_hold (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .frame_start (frame_start),
    .chan_in     (chan_code),
    .cur_code    (cur_code)
  );

  psw_code_match #(.W(CNT_W)) u_match (
    .cnt   (cnt),
    .code  (cur_code),
    .match (match)
  );

  psw_phase_ctrl u_phase (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .match   (match),
    .phase_q (phase_q),
    .cnt_en  (cnt_en),
    .cnt_dn  (cnt_dn),
    .ld_top  (ld_top),
    .clr     (clr)
  );

  psw_toggle_counter #(.W(CNT_W), .LOAD_VAL(RELOAD)) u_counter (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .cnt_en (cnt_en),
    .cnt_dn (cnt_dn),
    .ld_top (ld_top),
    .clr    (clr),
    .q      (cnt)
  );

  assign mod_ctrl   = (phase_q == PH_UP);
  assign count_down = (phase_q == PH_DOWN);
  assign frame_done = (phase_q == PH_WRAP);

endmodule

// File: rtl/psw_mod_ctrl_chk.sv
module psw_mod_ctrl_chk #(
  parameter int RELOAD = 28
) (
  input logic clk,
  input logic rst_n,
  input logic mod_ctrl,
  input logic count_down,
  input logic frame_done
);

  localparam int FRAME_CYC = RELOAD + 4;
  localparam int GAP_W     = $clog2(FRAME_CYC + 1);

  logic [GAP_W-1:0] gap_q;
  logic             seen_q;

  // Cycles elapsed since the last done pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (frame_done) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != GAP_W'(FRAME_CYC)) begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  AST_MC_DN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mod_ctrl && count_down)); // R8

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (!mod_ctrl && !count_down)); // R7

  AST_RESTART_UP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> mod_ctrl); // R7

  AST_LOAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mod_ctrl) |-> (!count_down && !frame_done)); // R4

  AST_DOWN_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mod_ctrl) |=> count_down); // R4

  AST_DOWN_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(count_down) |-> frame_done); // R4

  AST_MC_RISE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_ctrl) |-> $past(frame_done)); // R3

  AST_FRAME_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && seen_q) |-> (gap_q == GAP_W'(FRAME_CYC - 1))); // R2

endmodule

bind psw_mod_ctrl psw_mod_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mod_ctrl   (mod_ctrl),
  .count_down (count_down),
  .frame_done (frame_done)
);

// File: tb/psw_mod_ctrl_bench.sv
module psw_mod_ctrl_bench;

  localparam int CLK_P = 10;

  typedef struct {
    int mc;
    int dn;
    bit full;
  } exp_t;

  logic       clk;
  logic       rst_n;
  logic [4:0] chan_code;
  logic       mod_ctrl;
  logic       count_down;
  logic       frame_done;

  int   n_chk;
  int   n_bad;
  exp_t sb[$];

  // monitor state
  int len_cnt;
  int mc_cnt;
  int dn_cnt;
  bit have_done;
  bit prev_done;
  bit prev_mc;
  bit mc_ended;
  bit shape_bad;

  psw_mod_ctrl u_psw_mod_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .chan_code  (chan_code),
    .mod_ctrl   (mod_ctrl),
    .count_down (count_down),
    .frame_done (frame_done)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int eff_code(input int c);
    return (c > 27) ? 27 : c;
  endfunction

  function automatic exp_t make_exp(input int c, input bit full);
    exp_t e;
    e.mc   = eff_code(c) + 1;
    e.dn   = 29 - eff_code(c);
    e.full = full;
    return e;
  endfunction

  // Monitor: observes one cycle per falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      len_cnt   = 0;
      mc_cnt    = 0;
      dn_cnt    = 0;
      have_done = 1'b0;
      prev_done = 1'b0;
      prev_mc   = 1'b1;
      mc_ended  = 1'b0;
      shape_bad = 1'b0;
    end else begin
      len_cnt++;
      if (mod_ctrl) mc_cnt++;
      if (count_down) dn_cnt++;
      if (mod_ctrl && mc_ended) shape_bad = 1'b1;      // R3 contiguity
      if (!mod_ctrl) mc_ended = 1'b1;
      if (mod_ctrl && count_down) shape_bad = 1'b1;    // R8
      if (prev_done) chk(mod_ctrl == 1'b1, "R7 restart", int'(mod_ctrl), 1);
      if (prev_mc && !mod_ctrl)                        // R4 reload cycle
        chk(!count_down && !frame_done, "R4 reload", int'({count_down, frame_done}), 0);
      if (frame_done) begin
        exp_t e;
        chk(!mod_ctrl && !count_down, "R7 done quiet", int'({mod_ctrl, count_down}), 0);
        if (sb.size() == 0) begin
          chk(1'b0, "R2 unexpected frame", 1, 0);
        end else begin
          e = sb.pop_front();
          if (e.full && have_done) begin
            chk(len_cnt == 32, "R2 frame length", len_cnt, 32);
            chk(mc_cnt == e.mc, "R3 mod_ctrl count", mc_cnt, e.mc);
          end
          chk(dn_cnt == e.dn, "R4 count_down run", dn_cnt, e.dn);
          chk(!shape_bad, "R8 R3 shape", int'(shape_bad), 0);
        end
        have_done = 1'b1;
        len_cnt   = 0;
        mc_cnt    = 0;
        dn_cnt    = 0;
        mc_ended  = 1'b0;
        shape_bad = 1'b0;
      end
      prev_done = frame_done;
      prev_mc   = mod_ctrl;
    end
  end

  // Driver: at the end of a frame set the code for the next one and push
  // its expectation; optionally disturb the code inside that frame.
  task automatic next_frame(input int code, input int mid_at, input int mid_code);
    do @(negedge clk); while (!frame_done);
    chan_code = 5'(code);
    sb.push_back(make_exp(code, 1'b1));
    if (mid_at > 0) begin
      repeat (mid_at) @(negedge clk);
      chan_code = 5'(mid_code);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk     = 0;
    n_bad     = 0;
    rst_n     = 1'b0;
    chan_code = 5'd7;
    repeat (3) @(negedge clk);
    chk(mod_ctrl && !count_down && !frame_done, "R1 reset state",
        int'({mod_ctrl, count_down, frame_done}), 4);
    chan_code = 5'd30;
    @(negedge clk);
    chk(mod_ctrl && !count_down && !frame_done, "R1 reset ignores code",
        int'({mod_ctrl, count_down, frame_done}), 4);
    chan_code = 5'd7;
    sb.push_back(make_exp(7, 1'b0));
    rst_n = 1'b1;

    next_frame(7, 0, 0);
    next_frame(0, 0, 0);
    next_frame(27, 0, 0);
    next_frame(31, 0, 0);     // R5 clamp
    next_frame(28, 0, 0);     // R5 clamp
    next_frame(13, 3, 2);     // R6 mid-frame change
    next_frame(19, 5, 31);    // R6 mid-frame change to out-of-range

    // R1: asynchronous reset in the middle of a frame
    next_frame(5, 0, 0);
    repeat (10) @(negedge clk);
    #2;
    rst_n = 1'b0;
    #1;
    chk(mod_ctrl && !count_down && !frame_done, "R1 async reset",
        int'({mod_ctrl, count_down, frame_done}), 4);
    sb.delete();
    @(negedge clk);
    chan_code = 5'd9;
    sb.push_back(make_exp(9, 1'b0));
    @(negedge clk);
    rst_n = 1'b1;

    next_frame(1, 0, 0);
    next_frame(26, 0, 0);
    next_frame(16, 2, 0);
    do @(negedge clk); while (!frame_done);
    @(negedge clk);
    chk(sb.size() == 0, "R2 scoreboard drained", sb.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule